// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a 32-bit timer peripheral with a simple register bus. A prescale counter divides the peripheral clock. Each time it completes a period, an up-counting timer count advances by one. A single compare channel watches the timer count. When the count reaches the compare value, the channel can do any mix of three things: raise a level interrupt, return the count to zero, or halt the timer.

Software uses it in two ways. As a free-running time base, it is enabled with no prescale and no compare actions, and the count is read whenever needed. As a one-shot delay, the compare value is 1 and all three actions are on. Software holds the counters cleared, writes the delay into the prescale register and releases the timer. One interrupt arrives after the programmed delay, and the timer then stops by itself.

The bus uses byte offsets. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Register map, by byte offset:

| Offset | Register | Fields |
|---|---|---|
| 0x000 | Flag | Bit 0 is the match flag. |
| 0x004 | Control | Bit 0 is run. Bit 1 is hold. |
| 0x008 | Count | Timer count. |
| 0x00C | Prescale | Prescale limit. |
| 0x014 | Action | Bit 0 is interrupt. Bit 1 is clear-on-hit. Bit 2 is stop-on-hit. |
| 0x018 | Compare | Compare value. |
| 0x070 | Mode | Mode field, 2 bits. |

Top module: `pmt_timer`

## Requirements
- R1: After reset every register reads zero, the timer does not count, and `irq` is low.
- R2: The prescale and compare registers read back all 32 written bits. The action register reads back bits 2:0 and the mode register reads back bits 1:0. The other bits of these two registers read zero. Any offset outside the map, including misaligned ones, reads zero, and writes to it change no register.
- R3: While control bit 1 (hold) is set, the count and the prescale counter stay at zero.
- R4: With control bit 0 (run) set, hold clear and mode zero, the count advances by one every P+1 clocks, where P is the prescale value. P = 0 advances it every clock.
- R5: The count wraps from 0xFFFFFFFF to 0x00000000 and carries on counting.
- R6: A hit occurs in the cycle after the count has stepped onto the compare value. If action bit 0 is set, the hit sets flag bit 0 on the next edge. `irq` equals flag bit 0 AND action bit 0.
- R7: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.
- R8: With action bit 1 set, the edge after a hit returns the count and the prescale counter to zero.
- R9: With action bit 2 set, the edge after a hit clears control bit 0, and the count stays frozen at the compare value.
- R10: Take compare value 1, action value 7, hold set, prescale N, and then a control write of 1. `irq` rises exactly N+2 clock edges after that write and rises only once. The count then reads 0 and control reads 0.
- R11: A write to the count register loads it only while control bit 0 is clear. Otherwise the write is ignored.
- R12: A nonzero mode field stops the counters from advancing, even with run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The bench times the one-shot sequence to the exact edge for several prescale values. A design that matched on the incrementing edge, or that reloaded the prescaler one clock late, would raise `irq` one cycle early or late. A design that failed to stop would raise it again.

Clear-on-hit is checked with a nonzero prescale, to catch a prescale counter that is not restarted. Stop-on-hit is checked for the frozen count and for the cleared run bit. Wrap-around and writes to the count while running are covered, as are write-one-to-clear against write-zero on the flag and masking of `irq` by the enable bit. Unmapped and misaligned offsets are also covered: a sloppy decoder would alias them onto real registers.

// File: rtl/pmt_pkg.sv
// Shared constants and types for the prescaled match timer.
// Offsets are byte offsets on the register bus.
package pmt_pkg;
    localparam int unsigned OFF_FLAG    = 'h000;
    localparam int unsigned OFF_CTRL    = 'h004;
    localparam int unsigned OFF_COUNT   = 'h008;
    localparam int unsigned OFF_PSCL    = 'h00C;
    localparam int unsigned OFF_ACT     = 'h014;
    localparam int unsigned OFF_CMP     = 'h018;
    localparam int unsigned OFF_MODE    = 'h070;
    localparam int unsigned MODE_W      = 2;

    // Actions on a compare hit; bit 0 interrupt, bit 1 clear, bit 2 stop.
    typedef struct packed {
        logic stop_on_hit;
        logic clear_on_hit;
        logic irq_on_hit;
    } hit_act_t;
endpackage

// File: rtl/pmt_count.sv
// Prescale counter and timer count.
// Assumes: hold has top priority, then a clear on a hit, then a software
// load. A stop on a hit suppresses advancing on that edge. The step output
// marks the cycle after the count advanced.
module pmt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             hold,
    input  logic             do_clear,
    input  logic             do_stop,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] pscl,
    output logic [CNT_W-1:0] tc,
    output logic             stepped
);
    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] tc_q;
    logic             step_q;

    // Advance, clear or load the counters each clock.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pc_q   <= '0;
            tc_q   <= '0;
            step_q <= 1'b0;
        end else if (do_clear) begin
            pc_q   <= '0;
            tc_q   <= '0;
            step_q <= 1'b0;
        end else if (wr_count) begin
            tc_q   <= wr_val;
            step_q <= 1'b0;
        end else if (cnt_en && !do_stop) begin
            if (pc_q >= pscl) begin
                pc_q   <= '0;
                tc_q   <= tc_q + 1'b1;
                step_q <= 1'b1;
            end else begin
                pc_q   <= pc_q + 1'b1;
                step_q <= 1'b0;
            end
        end else begin
            step_q <= 1'b0;
        end
    end

    assign tc      = tc_q;
    assign stepped = step_q;

    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (tc_q == '0 && pc_q == '0));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_clear && !hold) |=> (tc_q == '0 && pc_q == '0));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !hold && !do_clear && !do_stop && !wr_count)
        |=> (tc_q == $past(tc_q) || tc_q == CNT_W'($past(tc_q) + 1'b1)));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !hold && !do_clear && !wr_count) |=> $stable(tc_q));
endmodule

// File: rtl/pmt_match.sv
// Compare channel.
// Reports a hit when the count has just stepped onto the compare value,
// and turns the hit into the enabled actions. Purely combinational.
module pmt_match import pmt_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic             stepped,
    input  logic [CNT_W-1:0] tc,
    input  logic [CNT_W-1:0] cmp,
    input  hit_act_t         act,
    output logic             do_flag,
    output logic             do_clear,
    output logic             do_stop
);
    logic hit;

    // Qualify equality with the step so a held or loaded value never hits.
    always_comb begin
        hit      = stepped && (tc == cmp);
        do_flag  = hit && act.irq_on_hit;
        do_clear = hit && act.clear_on_hit;
        do_stop  = hit && act.stop_on_hit;
    end
endmodule

// File: rtl/pmt_regs.sv
// Register file and read decode.
// Assumes byte offsets with an exact match; anything else reads zero and
// ignores writes. A stop on a hit overrides a control write on the same
// edge. A flag set overrides a write-one clear on the same edge.
module pmt_regs import pmt_pkg::*; #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  tc,
    input  logic              do_flag,
    input  logic              do_stop,
    output logic              run,
    output logic              hold,
    output logic [CNT_W-1:0]  pscl,
    output logic [CNT_W-1:0]  cmp,
    output hit_act_t          act,
    output logic [MODE_W-1:0] mode,
    output logic              wr_count,
    output logic              irq
);
    localparam int ACT_W = $bits(hit_act_t);

    logic              run_q, hold_q, flag_q;
    logic [CNT_W-1:0]  pscl_q, cmp_q;
    hit_act_t          act_q;
    logic [MODE_W-1:0] mode_q;
    logic sel_flag, sel_ctrl, sel_count, sel_pscl, sel_act, sel_cmp, sel_mode;

    // Decode the offset into one select per register.
    always_comb begin
        sel_flag  = bus_addr == ADDR_W'(OFF_FLAG);
        sel_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
        sel_count = bus_addr == ADDR_W'(OFF_COUNT);
        sel_pscl  = bus_addr == ADDR_W'(OFF_PSCL);
        sel_act   = bus_addr == ADDR_W'(OFF_ACT);
        sel_cmp   = bus_addr == ADDR_W'(OFF_CMP);
        sel_mode  = bus_addr == ADDR_W'(OFF_MODE);
    end

    // Control bits; a stop from the compare channel clears run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (bus_wr && sel_ctrl) begin
                run_q  <= bus_wdata[0];
                hold_q <= bus_wdata[1];
            end
            if (do_stop) run_q <= 1'b0;
        end
    end

    // Configuration registers written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pscl_q <= '0;
            cmp_q  <= '0;
            act_q  <= '0;
            mode_q <= '0;
        end else if (bus_wr) begin
            if (sel_pscl) pscl_q <= bus_wdata;
            if (sel_cmp)  cmp_q  <= bus_wdata;
            if (sel_act)  act_q  <= hit_act_t'(bus_wdata[ACT_W-1:0]);
            if (sel_mode) mode_q <= bus_wdata[MODE_W-1:0];
        end
    end

    // Match flag: set by a hit, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 flag_q <= 1'b0;
        else if (do_flag)                           flag_q <= 1'b1;
        else if (bus_wr && sel_flag && bus_wdata[0]) flag_q <= 1'b0;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_flag)       bus_rdata[0]          = flag_q;
        else if (sel_ctrl)  bus_rdata[1:0]        = {hold_q, run_q};
        else if (sel_count) bus_rdata             = tc;
        else if (sel_pscl)  bus_rdata             = pscl_q;
        else if (sel_act)   bus_rdata[ACT_W-1:0]  = act_q;
        else if (sel_cmp)   bus_rdata             = cmp_q;
        else if (sel_mode)  bus_rdata[MODE_W-1:0] = mode_q;
    end

    assign run      = run_q;
    assign hold     = hold_q;
    assign pscl     = pscl_q;
    assign cmp      = cmp_q;
    assign act      = act_q;
    assign mode     = mode_q;
    assign wr_count = bus_wr && sel_count && !run_q;
    assign irq      = flag_q && act_q.irq_on_hit;

    assert_stop_clears_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_stop |=> !run_q);

    assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_flag |=> flag_q);

    assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_flag && bus_wdata[0] && !do_flag) |=> !flag_q);

    assert_flag_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_flag && !bus_wdata[0] && flag_q) |=> flag_q);
endmodule

// File: rtl/pmt_timer.sv
// Prescaled match timer, top level.
// Joins the register file, the counters and the compare channel.
// Counting is allowed only in timer mode (mode field zero).
module pmt_timer import pmt_pkg::*; #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic              run, hold, wr_count, stepped, cnt_en;
    logic              do_flag, do_clear, do_stop;
    logic [CNT_W-1:0]  pscl, cmp, tc;
    hit_act_t          act;
    logic [MODE_W-1:0] mode;

    // Advance only when running in timer mode.
    always_comb cnt_en = run && (mode == '0);

    pmt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc(tc),
        .do_flag(do_flag), .do_stop(do_stop), .run(run), .hold(hold),
        .pscl(pscl), .cmp(cmp), .act(act), .mode(mode),
        .wr_count(wr_count), .irq(irq)
    );

    pmt_count #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hold(hold),
        .do_clear(do_clear), .do_stop(do_stop), .wr_count(wr_count),
        .wr_val(bus_wdata), .pscl(pscl), .tc(tc), .stepped(stepped)
    );

    pmt_match #(.CNT_W(CNT_W)) match_i (
        .stepped(stepped), .tc(tc), .cmp(cmp), .act(act),
        .do_flag(do_flag), .do_clear(do_clear), .do_stop(do_stop)
    );
endmodule

// File: tb/pmt_timer_tb_top.sv
module pmt_timer_tb_top;
    localparam logic [7:0] A_FLAG = 8'h00, A_CTRL = 8'h04, A_COUNT = 8'h08,
                           A_PSCL = 8'h0C, A_ACT = 8'h14, A_CMP = 8'h18,
                           A_MODE = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int irq_rises = 0;
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Count rising edges of irq, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && irq && !irq_prev) irq_rises++;
        irq_prev <= irq;
    end

    // Expected count after k edges with prescale p, starting from zero.
    function automatic logic [31:0] exp_count(int unsigned k, int unsigned p);
        return 32'(k / (p + 1));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(int unsigned k);
        repeat (k) @(negedge clk);
    endtask

    // Hold, load prescale, then release with run; returns just after the run edge.
    task automatic start(logic [31:0] p);
        wr(A_CTRL, 32'h2);
        wr(A_PSCL, p);
        wr(A_CTRL, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned offs[7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h70};
        int unsigned bad[7]  = '{8'h10, 8'h1C, 8'h20, 8'h6C, 8'h74, 8'h05, 8'hFC};
        int unsigned r0;
        r0 = $urandom(32'h1234_5EED);
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        for (int i = 0; i < 7; i++) begin
            rd(8'(offs[i]), v);
            chk("R1", $sformatf("reg %h after reset", offs[i]), v, 32'h0);
        end
        wait_edges(5);
        rd(A_COUNT, v); chk("R1", "count idle after reset", v, 32'h0);
        chk("R1", "irq after reset", {31'h0, irq}, 32'h0);

        // R2: random read-back with field masks.
        for (int i = 0; i < 8; i++) begin
            logic [31:0] d;
            d = $urandom;
            wr(A_PSCL, d);  rd(A_PSCL, v); chk("R2", "prescale readback", v, d);
            wr(A_CMP, ~d);  rd(A_CMP, v);  chk("R2", "compare readback", v, ~d);
            wr(A_ACT, d);   rd(A_ACT, v);  chk("R2", "action readback", v, d & 32'h7);
            wr(A_MODE, d);  rd(A_MODE, v); chk("R2", "mode readback", v, d & 32'h3);
        end
        wr(A_PSCL, 0); wr(A_CMP, 0); wr(A_ACT, 0); wr(A_MODE, 0);

        // R2: unmapped and misaligned offsets.
        for (int i = 0; i < 7; i++) begin
            wr(8'(bad[i]), 32'hFFFF_FFFF);
            rd(8'(bad[i]), v);
            chk("R2", $sformatf("unmapped %h", bad[i]), v, 32'h0);
        end
        for (int i = 0; i < 7; i++) begin
            rd(8'(offs[i]), v);
            chk("R2", $sformatf("reg %h untouched by unmapped writes", offs[i]), v, 32'h0);
        end

        // R4: random prescale values and run lengths.
        for (int i = 0; i < 12; i++) begin
            int unsigned p, k;
            p = $urandom_range(0, 6);
            k = $urandom_range(0, 40);
            wr(A_CMP, 32'hFFFF_0000);
            start(p);
            wait_edges(k);
            rd(A_COUNT, v);
            chk("R4", $sformatf("count p=%0d k=%0d", p, k), v, exp_count(k, p));
            wr(A_CTRL, 0);
        end

        // R3: hold forces zero even while running.
        start(0);
        wait_edges(5);
        wr(A_CTRL, 32'h3);
        wait_edges(4);
        rd(A_COUNT, v); chk("R3", "count under hold", v, 32'h0);
        wr(A_CTRL, 32'h1);
        wait_edges(3);
        rd(A_COUNT, v); chk("R3", "count restarts from zero after hold", v, 32'h3);
        wr(A_CTRL, 0);

        // R12: nonzero mode blocks counting.
        wr(A_MODE, 32'h1);
        start(0);
        wait_edges(10);
        rd(A_COUNT, v); chk("R12", "count with mode 1", v, 32'h0);
        // R11: load ignored while run is set.
        wr(A_COUNT, 32'h1234);
        rd(A_COUNT, v); chk("R11", "count write while running", v, 32'h0);
        wr(A_CTRL, 0);
        wr(A_COUNT, 32'h1234);
        rd(A_COUNT, v); chk("R11", "count write while stopped", v, 32'h1234);
        wr(A_MODE, 0);

        // R5: wrap-around.
        wr(A_CTRL, 32'h2); wr(A_CTRL, 0);
        wr(A_CMP, 32'h5555);
        wr(A_COUNT, 32'hFFFF_FFFE);
        wr(A_PSCL, 0);
        wr(A_CTRL, 32'h1);
        wait_edges(1);
        rd(A_COUNT, v); chk("R5", "count before wrap", v, 32'hFFFF_FFFF);
        wait_edges(1);
        rd(A_COUNT, v); chk("R5", "count wraps to zero", v, 32'h0);
        wait_edges(2);
        rd(A_COUNT, v); chk("R5", "count after wrap", v, 32'h2);
        wr(A_CTRL, 0);

        // R6: hit without interrupt enable leaves the flag clear.
        wr(A_ACT, 0); wr(A_CMP, 3);
        start(0);
        wait_edges(8);
        rd(A_FLAG, v); chk("R6", "flag with action 0", v, 32'h0);
        chk("R6", "irq with action 0", {31'h0, irq}, 32'h0);
        wr(A_CTRL, 0);

        // R6: flag timing with interrupt enabled.
        wr(A_ACT, 32'h1);
        start(0);
        wait_edges(3);
        chk("R6", "irq one edge before flag", {31'h0, irq}, 32'h0);
        wait_edges(1);
        chk("R6", "irq on the edge after hit", {31'h0, irq}, 32'h1);
        rd(A_COUNT, v); chk("R6", "count keeps going without actions", v, 32'h4);
        wr(A_CTRL, 0);
        wr(A_ACT, 0);
        chk("R6", "irq masked by enable", {31'h0, irq}, 32'h0);
        rd(A_FLAG, v); chk("R6", "flag kept while masked", v, 32'h1);
        wr(A_ACT, 32'h1);
        chk("R6", "irq unmasked", {31'h0, irq}, 32'h1);

        // R7: write-one clears, write-zero keeps.
        wr(A_FLAG, 0);
        rd(A_FLAG, v); chk("R7", "flag after writing 0", v, 32'h1);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v); chk("R7", "flag after writing 1", v, 32'h0);
        chk("R7", "irq after clear", {31'h0, irq}, 32'h0);

        // R8: clear-on-hit with prescale 1 restarts the prescaler.
        wr(A_ACT, 32'h3); wr(A_CMP, 3);
        start(1);
        wait_edges(6);
        rd(A_COUNT, v); chk("R8", "count reaches compare", v, 32'h3);
        wait_edges(1);
        rd(A_COUNT, v); chk("R8", "count cleared after hit", v, 32'h0);
        wait_edges(1);
        rd(A_COUNT, v); chk("R8", "prescaler restarted", v, 32'h0);
        wait_edges(1);
        rd(A_COUNT, v); chk("R8", "count resumes", v, 32'h1);
        wr(A_CTRL, 0); wr(A_FLAG, 1);

        // R9: stop-on-hit freezes count and clears run.
        wr(A_ACT, 32'h4); wr(A_CMP, 3);
        start(0);
        wait_edges(4);
        rd(A_COUNT, v); chk("R9", "count frozen at compare", v, 32'h3);
        rd(A_CTRL, v);  chk("R9", "run cleared", v, 32'h0);
        wait_edges(6);
        rd(A_COUNT, v); chk("R9", "count still frozen", v, 32'h3);

        // R10: one-shot delay for several prescale values.
        for (int i = 0; i < 3; i++) begin
            int unsigned n, rises0;
            n = (i == 0) ? 0 : (i == 1) ? 5 : $urandom_range(2, 20);
            wr(A_CMP, 1); wr(A_ACT, 32'h7);
            rises0 = irq_rises;
            start(n);
            wait_edges(n + 1);
            chk("R10", $sformatf("irq before delay n=%0d", n), {31'h0, irq}, 32'h0);
            rd(A_COUNT, v); chk("R10", "count at compare", v, 32'h1);
            wait_edges(1);
            chk("R10", $sformatf("irq at delay n=%0d", n), {31'h0, irq}, 32'h1);
            rd(A_COUNT, v); chk("R10", "count cleared", v, 32'h0);
            rd(A_CTRL, v);  chk("R10", "timer halted", v, 32'h0);
            wait_edges(n + 20);
            rd(A_COUNT, v); chk("R10", "count stays zero", v, 32'h0);
            chk("R10", "single interrupt", 32'(irq_rises - rises0), 32'h1);
            wr(A_FLAG, 1);
            chk("R10", "irq cleared", {31'h0, irq}, 32'h0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule